// File: doc/BRIEF.md
# Timing-Guarded Capture Register

This block captures the result word of a datapath, for example a 33-bit sum with its carry out, and detects when that word was still changing at the moment of capture. Every bit has two storage elements fed by the same data: an edge-triggered main register on the main clock, and a level-sensitive shadow latch that is open while a second, delayed copy of the clock is high. Because the shadow closes later than the main register samples, it holds the value a slow path finally settled to. When the two copies disagree, the main register took a stale value.

The disagreement is sampled on each bit when the delayed clock falls. An OR across all bits gives a word-level error. On the following main edge the block throws away the stale word, loads the shadow value into the output register, drops the output-valid flag for that one cycle, and raises a stall so that upstream logic holds or replays its input. A saturating counter records how many such repair events have happened since the last reset.

The delayed clock comes in as a plain input. Generating it and guarding against metastability are left to the surrounding design. The delayed clock must rise after the main clock and fall before the next main rising edge.

Top module: `timing_guard_reg`

## Requirements
- R1: While `rst` is high at a main clock edge, `q_out` is cleared to zero, `q_valid` and `stall` are 0 and `err_count` is 0. While `rst` is high at a delayed-clock falling edge, `bit_err` is cleared to zero.
- R2: If `d_in` is stable from before a main rising edge until after the following delayed-clock falling edge, `q_out` shows that value from that main edge on. In that case `q_valid` is 1, and `bit_err` and `bank_err` stay 0.
- R3: At each delayed-clock falling edge outside a stall cycle, bit i of `bit_err` is set to the XOR of bit i of `q_out` and bit i of the shadow latch. The shadow latch holds the last value `d_in` had while `clk_dly` was high. `bank_err` is 1 when any bit of `bit_err` is 1.
- R4: At a main edge where `bank_err` is 1, `q_out` loads the shadow value, which is the late data, and not `d_in`.
- R5: In the cycle after such a repair edge, `stall` is 1 and `q_valid` is 0, for exactly one cycle. The comparison made at the delayed-clock fall inside that stall cycle is forced to zero, so a change on `d_in` during the stall cycle raises no error.
- R6: `err_count` (CNT_W bits, default 8) rises by one at each repair edge and holds its value at every other edge. It saturates at 2^CNT_W-1 (255) and only `rst` clears it.
- R7: At the main edge after a stall cycle, `stall` returns to 0, `q_valid` returns to 1 and `q_out` captures `d_in` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; the output register samples on its rising edge |
| clk_dly | input | 1 | Delayed clock; the shadow latch is open while it is high |
| rst | input | 1 | Synchronous reset, active high |
| d_in | input | WIDTH | Result word from the datapath |
| q_out | output | WIDTH | Captured, or repaired, result word |
| q_valid | output | 1 | q_out holds a word that can be used |
| bit_err | output | WIDTH | Per-bit mismatch, sampled at the delayed-clock fall |
| bank_err | output | 1 | OR of all bit_err bits |
| stall | output | 1 | Hold or replay request, one cycle per repair |
| err_count | output | CNT_W | Saturating count of repair events |

## Verification
The assertions check on every main edge the parts of the behaviour that depend only on registers:
- an asserted word error is followed by a repair from the shadow value, a one-cycle stall with valid low, and a count step;
- the counter stays put when there is no error;
- after a stall, normal capture resumes.

Only the bench's timed scenarios can show the per-bit mismatch pattern. That pattern needs data that moves between the main edge and the delayed edge. The bench's scenarios also show that the late value, not the stale one, ends up on the output, that a change inside a stall cycle is masked, and that the counter saturates and clears.

// File: rtl/timing_guard_reg.sv
module timing_guard_reg #(
  parameter int WIDTH = 33,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             clk_dly,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out,
  output logic             q_valid,
  output logic [WIDTH-1:0] bit_err,
  output logic             bank_err,
  output logic             stall,
  output logic [CNT_W-1:0] err_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] shadow;
  logic [WIDTH-1:0] mism;

  // shadow copy: open while the delayed clock is high
  always_latch begin
    if (clk_dly) shadow <= d_in;
  end

  assign mism = q_out ^ shadow;

  // compare once the shadow has closed; masked during the repair cycle
  always_ff @(negedge clk_dly) begin
    if (rst || stall) bit_err <= '0;
    else              bit_err <= mism;
  end

  assign bank_err = |bit_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out     <= '0;
      q_valid   <= 1'b0;
      stall     <= 1'b0;
      err_count <= '0;
    end else begin
      q_out   <= bank_err ? shadow : d_in;
      stall   <= bank_err;
      q_valid <= !bank_err;
      if (bank_err && err_count != CNT_MAX)
        err_count <= err_count + 1'b1;
    end
  end

  a_r2_clean_capture: assert property (@(posedge clk) disable iff (rst)
    !bank_err |=> (q_valid && q_out == $past(d_in)));

  a_r4_repair_from_shadow: assert property (@(posedge clk) disable iff (rst)
    bank_err |=> (q_out == $past(shadow)));

  a_r5_stall_marks_invalid: assert property (@(posedge clk) disable iff (rst)
    bank_err |=> (stall && !q_valid));

  a_r5_stall_one_cycle: assert property (@(posedge clk) disable iff (rst)
    stall |=> !stall);

  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    (bank_err && err_count != CNT_MAX) |=> (err_count == $past(err_count) + 1'b1));

  a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
    !bank_err |=> $stable(err_count));

  a_r7_resume: assert property (@(posedge clk) disable iff (rst)
    stall |=> (q_valid && !stall));

endmodule

// File: tb/timing_guard_reg_tb.sv
`timescale 1ns/100ps
module timing_guard_reg_tb_top;
  localparam int W = 33;

  logic         clk = 1'b0;
  logic         clk_dly = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] d_in = '0;
  logic [W-1:0] q_out, bit_err;
  logic         q_valid, bank_err, stall;
  logic [7:0]   err_count;

  int n_checks = 0;
  int n_fail = 0;
  int exp_cnt = 0;
  bit finished = 0;

  timing_guard_reg #(.WIDTH(W), .CNT_W(8)) dut_i (
    .clk(clk), .clk_dly(clk_dly), .rst(rst), .d_in(d_in),
    .q_out(q_out), .q_valid(q_valid), .bit_err(bit_err),
    .bank_err(bank_err), .stall(stall), .err_count(err_count)
  );

  // 250 MHz main clock; delayed copy trails by 1 ns
  initial forever #2 clk = ~clk;
  initial begin #1; forever #2 clk_dly = ~clk_dly; end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  // value changes right after the delayed fall; captured at the next main edge
  task automatic drive_on_time(input logic [W-1:0] v);
    @(negedge clk_dly); #0.5; d_in = v;
    @(posedge clk); #0.25;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #0.25;
    check("R1 q_out", q_out, 0);
    check("R1 q_valid", q_valid, 0);
    check("R1 stall", stall, 0);
    check("R1 err_count", err_count, 0);
    @(negedge clk_dly); #0.25;
    check("R1 bit_err", bit_err, 0);
    exp_cnt = 0;
    @(posedge clk); #3.5;
    rst = 1'b0;
    @(posedge clk); #0.25;
  endtask

  task automatic t_on_time(input logic [W-1:0] v);
    drive_on_time(v);
    check("R2 q_out", q_out, v);
    check("R2 q_valid", q_valid, 1);
    check("R2 stall", stall, 0);
    #3.25;
    check("R2 bank_err", bank_err, 0);
    check("R2 bit_err", bit_err, 0);
  endtask

  // a is captured on time, then b arrives late after the main edge
  task automatic t_late(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit move_in_stall, input logic [W-1:0] c);
    drive_on_time(a);
    #0.25; d_in = b;
    #3.0;
    check("R3 bit_err", bit_err, a ^ b);
    check("R3 bank_err", bank_err, (a != b));
    @(posedge clk); #0.25;
    if (a != b) begin
      if (exp_cnt < 255) exp_cnt++;
      check("R4 repaired q_out", q_out, b);
      check("R5 stall", stall, 1);
      check("R5 q_valid", q_valid, 0);
      check("R6 err_count", err_count, exp_cnt);
      if (move_in_stall) begin #0.25; d_in = c; #3.0; end
      else #3.25;
      check("R5 masked bank_err", bank_err, 0);
      @(posedge clk); #0.25;
      check("R7 stall", stall, 0);
      check("R7 q_valid", q_valid, 1);
      check("R7 q_out", q_out, move_in_stall ? c : b);
      check("R6 err_count hold", err_count, exp_cnt);
    end else begin
      check("R2 q_out", q_out, b);
      check("R6 err_count hold", err_count, exp_cnt);
    end
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 260; i++)
      t_late(33'h0, 33'h1 << (i % W), 1'b0, 33'h0);
    check("R6 saturated", err_count, 255);
  endtask

  initial begin
    t_reset();
    t_on_time(33'h1_2345_6789);
    t_on_time(33'h0_FFFF_0000);
    t_on_time(33'h1_FFFF_FFFF);
    t_late(33'h0_0000_00F0, 33'h0_0000_00A5, 1'b0, 33'h0);
    t_late(33'h1_0000_0000, 33'h0_0000_0001, 1'b0, 33'h0);
    t_late(33'h0_5555_5555, 33'h0_5555_5555, 1'b0, 33'h0);
    t_late(33'h0_0000_0003, 33'h1_AAAA_AAAA, 1'b1, 33'h0_0F0F_0F0F);
    t_on_time(33'h0_1234_0000);
    t_saturate();
    t_reset();
    t_late(33'h0_0000_0000, 33'h0_8000_0000, 1'b0, 33'h0);
    summary();
  end

  initial begin
    #(200000 * 4);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule